// File: doc/BRIEF.md
# Reorder-Buffer Thread Share Allocator

This block decides how many reorder-buffer slots each hardware thread may hold in a multithreaded core. Software or the core's control logic picks one of three sharing policies. In the first, every thread may use the whole buffer. In the second, the buffer is split evenly among the threads that are active. In the third, each thread is capped at a programmable percentage of the buffer. The per-thread caps are held in registers. They are recomputed when a strobe is raised, and also on their own whenever the set of active threads changes.

From those caps and the per-thread occupancy counts that the dispatch logic supplies, the block derives three results with no added latency: a free-slot count for each thread, a full flag for each thread, and a free count and full flag for the buffer as a whole. The dispatch stage uses these signals to stall a thread that has reached its cap. The entry storage itself lives elsewhere.

Top module: `rob_share_alloc`

## Requirements
- R1: After reset every thread's cap equals NUM_ENTRIES (64 by default), and the record of the previous active mask is all zeros.
- R2: With the open policy, a recompute sets every thread's cap to NUM_ENTRIES, whatever the active mask.
- R3: With the even-split policy, each active thread gets NUM_ENTRIES divided by the number of set mask bits, rounded down, and each inactive thread gets 0. An all-zero mask gives every thread a cap of 0.
- R4: With the percentage policy, every thread gets floor(NUM_ENTRIES * pct / 100), with a minimum of 1. A pct above 100 is treated as 100.
- R5: The policy is selected by the code 2'b00 (open), 2'b01 (even split) or 2'b10 (percentage). The code 2'b11 behaves as open.
- R6: The caps are reloaded at a rising edge where `recompute` is high or `active_mask` differs from its value at the previous edge, and the new caps are visible right after that edge. At any other edge the caps hold, so a change of policy or pct alone has no effect.
- R7: A thread's free count is its cap minus its occupancy. It saturates at 0 when the occupancy is at or above the cap.
- R8: A thread's full flag is 1 exactly when its occupancy is greater than or equal to its cap.
- R9: The buffer free count is NUM_ENTRIES minus the sum of all occupancies, saturating at 0. `buffer_full` is 1 when that sum is at least NUM_ENTRIES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Sharing policy code |
| active_mask | input | NUM_THREADS | One bit per active thread |
| thresh_pct | input | 7 | Percentage used by the percentage policy |
| recompute | input | 1 | Strobe that reloads the caps |
| occupancy | input | NUM_THREADS*CNT_W | Per-thread occupied slots, thread 0 in the low bits |
| limit | output | NUM_THREADS*CNT_W | Per-thread caps, thread 0 in the low bits |
| free_cnt | output | NUM_THREADS*CNT_W | Per-thread free slots |
| full | output | NUM_THREADS | Per-thread full flags |
| total_free | output | CNT_W | Free slots in the whole buffer |
| buffer_full | output | 1 | Whole buffer occupied |

## Verification
A cap reload and the combinational free/full evaluation can take effect at the same edge. The reload can shrink a cap below an occupancy the thread already holds. The bench provokes this by holding thread 0 at 40 occupied slots under the open policy, then changing the active mask and the policy to even split in a single cycle. This checks both the reload that the mask change triggers and the saturation of the free count: right after that edge the bench expects a cap of 16, a free count of 0 and a raised full flag. A second collision, a strobe that arrives in the same cycle as a mask change, is also judged by the caps that follow the edge.

// File: rtl/rob_share_pkg.sv
package rob_share_pkg;

  typedef enum logic [1:0] {
    SHARE_OPEN  = 2'b00,
    SHARE_EVEN  = 2'b01,
    SHARE_PCT   = 2'b10,
    SHARE_RSVD  = 2'b11
  } share_policy_e;

  // Even split among active threads, truncating; zero when none active.
  function automatic int unsigned even_share(input int unsigned total,
                                             input int unsigned n_active);
    if (n_active == 0) return 0;
    return total / n_active;
  endfunction

  // Percentage cap, pct clipped to 100, result floored and kept >= 1.
  function automatic int unsigned pct_share(input int unsigned total,
                                            input int unsigned pct);
    int unsigned p;
    int unsigned v;
    p = (pct > 100) ? 100 : pct;
    v = (total * p) / 100;
    if (v == 0) v = 1;
    return v;
  endfunction

  // Saturating difference.
  function automatic int unsigned sat_sub(input int unsigned a,
                                          input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

endpackage

// File: rtl/share_limit_calc.sv
module share_limit_calc
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic [1:0]                   policy_sel,
  input  logic [NUM_THREADS-1:0]       active_mask,
  input  logic [6:0]                   thresh_pct,
  output logic [NUM_THREADS*CNT_W-1:0] next_limit
);

  localparam int unsigned TOTAL = NUM_ENTRIES;

  share_policy_e policy;
  int unsigned   n_active;
  logic [CNT_W-1:0] even_val;
  logic [CNT_W-1:0] pct_val;

  always_comb begin
    policy   = share_policy_e'(policy_sel);
    n_active = $countones(active_mask);
    even_val = CNT_W'(even_share(TOTAL, n_active));
    pct_val  = CNT_W'(pct_share(TOTAL, int'(thresh_pct)));
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_comb begin
      unique case (policy)
        SHARE_EVEN: next_limit[t*CNT_W +: CNT_W] = active_mask[t] ? even_val : '0;
        SHARE_PCT:  next_limit[t*CNT_W +: CNT_W] = pct_val;
        default:    next_limit[t*CNT_W +: CNT_W] = CNT_W'(TOTAL);
      endcase
    end
  end

endmodule

// File: rtl/share_limit_regs.sv
module share_limit_regs
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         recompute,
  input  logic [1:0]                   policy_sel,
  input  logic [NUM_THREADS-1:0]       active_mask,
  input  logic [NUM_THREADS*CNT_W-1:0] next_limit,
  output logic [NUM_THREADS*CNT_W-1:0] limit,
  output logic                         reload
);

  localparam int SUM_W = CNT_W + $clog2(NUM_THREADS) + 1;

  logic [NUM_THREADS-1:0] mask_q;
  logic                   mask_changed;
  logic                   live_q;

  assign mask_changed = (active_mask != mask_q);
  assign reload       = recompute | mask_changed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      live_q <= 1'b0;
      for (int t = 0; t < NUM_THREADS; t++)
        limit[t*CNT_W +: CNT_W] <= CNT_W'(NUM_ENTRIES);
    end else begin
      mask_q <= active_mask;
      live_q <= 1'b1;
      if (reload) limit <= next_limit;
    end
  end

  logic [SUM_W-1:0] limit_sum;
  always_comb begin
    limit_sum = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      limit_sum = limit_sum + SUM_W'(limit[t*CNT_W +: CNT_W]);
  end

  // R6: a reload edge takes the computed caps
  a_r6_reload_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live_q) && $past(reload)) |-> (limit == $past(next_limit)));

  // R6: without a reload the caps stay put
  a_r6_hold_caps: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live_q) && !$past(reload)) |-> $stable(limit));

  // R3: an even split never hands out more than the buffer
  a_r3_split_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(live_q) && $past(reload) && ($past(policy_sel) == 2'b01))
      |-> (limit_sum <= SUM_W'(NUM_ENTRIES)));

endmodule

// File: rtl/share_free_calc.sv
module share_free_calc
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS*CNT_W-1:0] limit,
  input  logic [NUM_THREADS*CNT_W-1:0] occupancy,
  output logic [NUM_THREADS*CNT_W-1:0] free_cnt,
  output logic [NUM_THREADS-1:0]       full
);

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] cap;
    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] avail;
    assign cap   = limit[t*CNT_W +: CNT_W];
    assign occ   = occupancy[t*CNT_W +: CNT_W];
    assign avail = CNT_W'(sat_sub(int'(cap), int'(occ)));
    assign free_cnt[t*CNT_W +: CNT_W] = avail;
    assign full[t] = (occ >= cap);

    // R7: free slots never exceed the cap
    a_r7_free_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
      avail <= cap);

    // R8: a thread is full exactly when nothing is left
    a_r8_full_no_free: assert property (@(posedge clk) disable iff (!rst_n)
      full[t] == (avail == '0));
  end

endmodule

// File: rtl/share_pool_count.sv
module share_pool_count
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS*CNT_W-1:0] occupancy,
  output logic [CNT_W-1:0]             total_free,
  output logic                         buffer_full
);

  localparam int SUM_W = CNT_W + $clog2(NUM_THREADS) + 1;

  logic [SUM_W-1:0] occ_sum;
  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NUM_THREADS; t++)
      occ_sum = occ_sum + SUM_W'(occupancy[t*CNT_W +: CNT_W]);
  end

  assign total_free  = CNT_W'(sat_sub(NUM_ENTRIES, int'(occ_sum)));
  assign buffer_full = (occ_sum >= SUM_W'(NUM_ENTRIES));

  // R9: free plus used accounts for the whole buffer when not oversubscribed
  a_r9_pool_conserved: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_sum <= SUM_W'(NUM_ENTRIES))
      |-> ((SUM_W'(total_free) + occ_sum) == SUM_W'(NUM_ENTRIES)));

endmodule

// File: rtl/rob_share_alloc.sv
module rob_share_alloc
  import rob_share_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   policy_sel,
  input  logic [NUM_THREADS-1:0]       active_mask,
  input  logic [6:0]                   thresh_pct,
  input  logic                         recompute,
  input  logic [NUM_THREADS*CNT_W-1:0] occupancy,
  output logic [NUM_THREADS*CNT_W-1:0] limit,
  output logic [NUM_THREADS*CNT_W-1:0] free_cnt,
  output logic [NUM_THREADS-1:0]       full,
  output logic [CNT_W-1:0]             total_free,
  output logic                         buffer_full
);

  logic [NUM_THREADS*CNT_W-1:0] next_limit;
  logic                         reload;

  share_limit_calc #(.NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_calc (
    .policy_sel (policy_sel),
    .active_mask(active_mask),
    .thresh_pct (thresh_pct),
    .next_limit (next_limit)
  );

  share_limit_regs #(.NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .recompute  (recompute),
    .policy_sel (policy_sel),
    .active_mask(active_mask),
    .next_limit (next_limit),
    .limit      (limit),
    .reload     (reload)
  );

  share_free_calc #(.NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .limit    (limit),
    .occupancy(occupancy),
    .free_cnt (free_cnt),
    .full     (full)
  );

  share_pool_count #(.NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .occupancy  (occupancy),
    .total_free (total_free),
    .buffer_full(buffer_full)
  );

  // R1: the first cycle out of reset shows full-size caps unless reloaded
  a_r1_reset_caps: assert property (@(posedge clk)
    ($past(!rst_n) && !$past(reload)) |-> (limit == {NUM_THREADS{CNT_W'(NUM_ENTRIES)}}));

endmodule

// File: tb/rob_share_alloc_tb.sv
module rob_share_alloc_tb;

  localparam int NT  = 4;
  localparam int NE  = 64;
  localparam int CW  = $clog2(NE + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    policy_sel;
  logic [NT-1:0] active_mask;
  logic [6:0]    thresh_pct;
  logic          recompute;
  logic [CW-1:0] occ [NT];
  logic [NT*CW-1:0] occupancy;
  logic [NT*CW-1:0] limit;
  logic [NT*CW-1:0] free_cnt;
  logic [NT-1:0]    full;
  logic [CW-1:0]    total_free;
  logic             buffer_full;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  always_comb
    for (int t = 0; t < NT; t++) occupancy[t*CW +: CW] = occ[t];

  rob_share_alloc #(.NUM_THREADS(NT), .NUM_ENTRIES(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .active_mask(active_mask),
    .thresh_pct(thresh_pct), .recompute(recompute), .occupancy(occupancy),
    .limit(limit), .free_cnt(free_cnt), .full(full),
    .total_free(total_free), .buffer_full(buffer_full)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model of the cap each thread should hold.
  function automatic int model_cap(input int pol, input logic [NT-1:0] m, input int pct, input int t);
    int bits = 0;
    int q;
    int p;
    for (int i = 0; i < NT; i++) if (m[i]) bits++;
    if (pol == 1) begin
      if (!m[t]) return 0;
      q = 0;
      while ((q + 1) * bits <= NE) q++;
      return q;
    end
    if (pol == 2) begin
      p = pct < 100 ? pct : 100;
      q = 0;
      while ((q + 1) * 100 <= NE * p) q++;
      return q < 1 ? 1 : q;
    end
    return NE;
  endfunction

  function automatic int cap_of(input int t);
    return int'(limit[t*CW +: CW]);
  endfunction

  task automatic check_caps(input string req, input int pol, input logic [NT-1:0] m, input int pct);
    for (int t = 0; t < NT; t++)
      check(req, $sformatf("cap t%0d pol%0d mask%b pct%0d", t, pol, m, pct),
            cap_of(t), model_cap(pol, m, pct, t));
  endtask

  // Drive on the falling edge, let one rising edge pass, sample at the next fall.
  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobe;
    recompute = 1'b1;
    step();
    recompute = 1'b0;
  endtask

  task automatic set_occ(input int a, input int b, input int c, input int d);
    occ[0] = CW'(a); occ[1] = CW'(b); occ[2] = CW'(c); occ[3] = CW'(d);
    #1;
  endtask

  task automatic t_reset;
    for (int t = 0; t < NT; t++) begin
      check("R1", $sformatf("reset cap t%0d", t), cap_of(t), NE);
      check("R1", $sformatf("reset full t%0d", t), int'(full[t]), 0);
    end
    check("R9", "reset total_free", int'(total_free), NE);
  endtask

  task automatic t_open;
    policy_sel = 2'b00; active_mask = 4'b0101; thresh_pct = 7'd10;
    strobe();
    check_caps("R2", 0, 4'b0101, 10);
  endtask

  task automatic t_even;
    policy_sel = 2'b01;
    active_mask = 4'b1111; step(); check_caps("R3", 1, 4'b1111, 0);
    active_mask = 4'b1011; step(); check_caps("R3", 1, 4'b1011, 0);
    active_mask = 4'b0001; step(); check_caps("R3", 1, 4'b0001, 0);
    active_mask = 4'b0000; step(); check_caps("R3", 1, 4'b0000, 0);
    check("R3", "all-zero mask cap t2", cap_of(2), 0);
    active_mask = 4'b0110; recompute = 1'b1; step(); recompute = 1'b0;
    check_caps("R6", 1, 4'b0110, 0);
  endtask

  task automatic t_pct;
    int pcts [5] = '{50, 33, 1, 0, 120};
    policy_sel = 2'b10;
    foreach (pcts[k]) begin
      thresh_pct = 7'(pcts[k]);
      strobe();
      check_caps("R4", 2, active_mask, pcts[k]);
    end
    check("R4", "pct 120 clipped", cap_of(0), 64);
  endtask

  task automatic t_rsvd;
    policy_sel = 2'b11; active_mask = 4'b0110;
    strobe();
    check_caps("R5", 3, 4'b0110, 0);
  endtask

  task automatic t_hold;
    policy_sel = 2'b01; active_mask = 4'b0110; thresh_pct = 7'd5;
    step();
    check_caps("R6", 0, 4'b0110, 0);
    policy_sel = 2'b10;
    step(); step();
    check_caps("R6", 0, 4'b0110, 0);
  endtask

  task automatic t_free;
    policy_sel = 2'b10; thresh_pct = 7'd25;
    strobe();
    set_occ(0, 10, 16, 30);
    check("R7", "free t0 empty", int'(free_cnt[0*CW +: CW]), 16);
    check("R7", "free t1 partial", int'(free_cnt[1*CW +: CW]), 6);
    check("R7", "free t3 over", int'(free_cnt[3*CW +: CW]), 0);
    check("R8", "full flags", int'(full), 4'b1100);
    check("R9", "total_free", int'(total_free), 8);
    check("R9", "buffer_full low", int'(buffer_full), 0);
    set_occ(40, 40, 0, 0);
    check("R9", "total_free saturates", int'(total_free), 0);
    check("R9", "buffer_full high", int'(buffer_full), 1);
    set_occ(0, 0, 0, 0);
  endtask

  task automatic t_collide;
    policy_sel = 2'b00; active_mask = 4'b0001;
    strobe();
    set_occ(40, 0, 0, 0);
    check("R8", "open cap not full", int'(full[0]), 0);
    check("R7", "open free t0", int'(free_cnt[0*CW +: CW]), 24);
    policy_sel = 2'b01; active_mask = 4'b1111;
    step();
    check("R3", "shrunk cap t0", cap_of(0), 16);
    check("R7", "free saturates after shrink", int'(free_cnt[0*CW +: CW]), 0);
    check("R8", "full after shrink", int'(full[0]), 1);
    set_occ(0, 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        rst_n = 1'b0; policy_sel = 2'b00; active_mask = '0; thresh_pct = '0;
        recompute = 1'b0;
        for (int t = 0; t < NT; t++) occ[t] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open();
        t_even();
        t_pct();
        t_rsvd();
        t_hold();
        t_free();
        t_collide();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule